// File: doc/BRIEF.md
# Multi-Mode Event and Quadrature Counter Channel

This block is one counter channel for an acquisition front end. It either totals debounced edges on a single pulse input, or it decodes a two-phase quadrature encoder with an optional index input into a signed position count. The raw inputs are asynchronous. Each one passes through a two-flop synchronizer and then a configurable noise filter before any edge or phase decoding.

A second channel's signal can be fed into the gate input. Depending on the configuration, that signal either enables counting or, in totalize mode, turns each counted edge into a decrement. The count register is 32 bits wide and can be narrowed to 16 bits. Software reaches the block through a small register port. Address 0 holds the configuration. Address 1 returns the count, and can optionally zero the count as it is sampled.

The filter time is chosen by a 4-bit code. The code selects one of sixteen durations between 0.5 us and 25.5 ms, which are converted to clock ticks for the configured clock frequency (48 MHz by default).

Top module: `multiModeCounter`

## Requirements
- R1: After reset the count is zero, `phaseErr` is low and the configuration register reads back as zero (totalize mode, 32-bit, rollover, rising edge, debounce with filter code 0).
- R2: A write to address 0 stores bits [14:0] as configuration, and reading address 0 returns them with bits [31:15] zero. The field map is: bit0 encoder mode, bit1 16-bit width, bit2 hold-at-max, bit3 clear-on-read, bit4 falling active edge, bit5 glitch-detect filter, bits[9:6] filter code, bits[11:10] multiplier (0 = x1, 1 = x2, 2/3 = x4), bit12 index clear enable, bits[14:13] gate mode (0 = none, 1 = enable, 2 = decrement). Read data appears on the cycle after `regRdEn`, with `regRdValid` high.
- R3: In totalize mode the count rises by one per active edge of the filtered pulse input. Bit4 picks the falling edge instead of the rising one, and the opposite edge leaves the count unchanged.
- R4: In debounce mode a filtered input follows its synchronized level only after that level has differed from the output for the coded number of ticks (code 0 = 24 ticks, code 1 = 48 ticks). Shorter pulses are not counted.
- R5: In glitch-detect mode the first change passes at once, and further changes are ignored for the coded number of ticks. A 3-cycle pulse, or two such pulses inside one lockout window, therefore counts as one edge.
- R6: In totalize mode with hold-at-max set, the count stays at its maximum on increment and stays at zero on decrement. With hold-at-max clear, the count wraps in both directions.
- R7: With the 16-bit width selected, the count wraps at 0xFFFF and bits [31:16] read as zero. With 32-bit width, a decrement from zero gives 0xFFFFFFFF.
- R8: A read of address 1 with clear-on-read set returns the count and leaves it at zero. Without clear-on-read the count is kept.
- R9: In gate-enable mode, edges are counted only while the synchronized gate is high. In gate-decrement mode (totalize), an edge seen with the gate high subtracts one.
- R10: In encoder mode a full forward cycle of phase states 00→10→11→01→00 (A,B) adds 1, 2 or 4 for x1, x2 or x4. The reverse cycle subtracts the same amount.
- R11: In encoder mode with index clear enabled, a rising edge of the filtered index input zeroes the count. With the enable clear, the index input has no effect.
- R12: In encoder mode, a transition in which both filtered phases change at once raises `phaseErr` for exactly one cycle and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseA | input | 1 | Pulse input (totalize) or phase A (encoder), asynchronous |
| phaseB | input | 1 | Phase B, asynchronous |
| indexZ | input | 1 | Index input, asynchronous |
| gateIn | input | 1 | Gate/direction signal from another channel, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 = configuration, 1 = count) |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 32 | Read data, valid with regRdValid |
| regRdValid | output | 1 | High on the cycle after a read strobe |
| countOut | output | 32 | Live count, masked to the selected width |
| phaseErr | output | 1 | One-cycle flag for an illegal quadrature transition |

## Verification
Most internal faults show up on `countOut` within a few cycles of the filtered edge that caused them:
- A filter counter that is off by a few ticks lets a pulse just below the limit through, or rejects one just above it. The count then differs by one once the settle window has passed.
- A wrong phase-decode entry makes a full encoder cycle return a net count other than plus or minus 1, 2 or 4.
- A bad wrap or saturation path is visible as soon as the single edge at the boundary is counted.

A wrong clear-on-read path appears on the second read of the count, which should then return zero.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  localparam int CFG_W = 15;
  localparam logic [1:0] ADDR_CFG   = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;

  typedef enum logic [1:0] {
    GATE_NONE   = 2'd0,
    GATE_ENABLE = 2'd1,
    GATE_DOWN   = 2'd2,
    GATE_SPARE  = 2'd3
  } gateMode_e;

  typedef enum logic [1:0] {
    MULT_X1     = 2'd0,
    MULT_X2     = 2'd1,
    MULT_X4     = 2'd2,
    MULT_X4_ALT = 2'd3
  } quadMult_e;

  // Packed: first member is the MSB, so gateMode sits at [14:13].
  typedef struct packed {
    gateMode_e  gateMode;
    logic       idxClrEn;
    quadMult_e  quadMult;
    logic [3:0] filtCode;
    logic       glitchMode;
    logic       fallEdge;
    logic       clrOnRead;
    logic       holdMax;
    logic       width16;
    logic       encMode;
  } chanCfg_t;

  typedef struct packed {
    logic up;
    logic down;
    logic idxClear;
    logic hostClear;
  } stepStrobes_t;

  // Filter duration for a 4-bit code, in clock ticks at clkMhz.
  function automatic int filterTicks(input logic [3:0] code, input int clkMhz);
    longint ns;
    longint t;
    case (code)
      4'd0:  ns = 500;
      4'd1:  ns = 1000;
      4'd2:  ns = 2000;
      4'd3:  ns = 5000;
      4'd4:  ns = 10000;
      4'd5:  ns = 20000;
      4'd6:  ns = 50000;
      4'd7:  ns = 100000;
      4'd8:  ns = 200000;
      4'd9:  ns = 500000;
      4'd10: ns = 1000000;
      4'd11: ns = 2000000;
      4'd12: ns = 5000000;
      4'd13: ns = 10000000;
      4'd14: ns = 20000000;
      default: ns = 25500000;
    endcase
    t = (ns * longint'(clkMhz)) / 1000;
    if (t < 1) t = 1;
    return int'(t);
  endfunction

endpackage

// File: rtl/mmc_input_filter.sv
module mmc_input_filter
  import mmc_pkg::*;
#(
  parameter int CLK_MHZ = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  logic [3:0] filtCode,
  input  logic       glitchMode,
  output logic       filtOut
);

  localparam int MAX_TICKS = filterTicks(4'hF, CLK_MHZ);
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  logic [1:0]        syncQ;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] tickLimit;
  logic              syncLvl;

  assign syncLvl   = syncQ[1];
  assign tickLimit = TICK_W'(filterTicks(filtCode, CLK_MHZ) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      tickCnt <= '0;
      filtOut <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (!glitchMode) begin
        // Debounce: level must disagree for the full window.
        if (syncLvl != filtOut) begin
          if (tickCnt >= tickLimit) begin
            filtOut <= syncLvl;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end else begin
          tickCnt <= '0;
        end
      end else begin
        // Glitch detect: pass first change, then lock out.
        if (tickCnt != '0) begin
          tickCnt <= tickCnt - 1'b1;
        end else if (syncLvl != filtOut) begin
          filtOut <= syncLvl;
          tickCnt <= tickLimit;
        end
      end
    end
  end

  // R4: a debounced change is preceded by a settled synchronized level.
  p_debounce_settled_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!glitchMode && $past(!glitchMode) && filtOut != $past(filtOut))
      |-> ($past(syncLvl, 2) == filtOut));

endmodule

// File: rtl/mmc_ctrl.sv
module mmc_ctrl
  import mmc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fA,
  input  logic              fB,
  input  logic              fZ,
  input  logic              gateRaw,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  input  logic [CNT_W-1:0]  countView,
  output chanCfg_t          cfg,
  output stepStrobes_t      strobes,
  output logic              phaseErr,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid
);

  chanCfg_t   cfgQ;
  logic [1:0] gateSync;
  logic       gateLvl;
  logic       prevA, prevB, prevZ;
  logic [3:0] qTrans;
  logic       qFwd, qRev, qErr, qUp, qDown;
  logic       actEdge, gateOk, tUp, tDown, errNow;
  logic       unusedWrBits;

  assign cfg          = cfgQ;
  assign gateLvl      = gateSync[1];
  assign unusedWrBits = ^regWrData[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ       <= '0;
      gateSync   <= '0;
      prevA      <= 1'b0;
      prevB      <= 1'b0;
      prevZ      <= 1'b0;
      phaseErr   <= 1'b0;
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CFG)
        cfgQ <= chanCfg_t'(regWrData[CFG_W-1:0]);
      gateSync   <= {gateSync[0], gateRaw};
      prevA      <= fA;
      prevB      <= fB;
      prevZ      <= fZ;
      phaseErr   <= errNow;
      regRdValid <= regRdEn;
      if (regRdEn) begin
        case (regAddr)
          ADDR_CFG:   regRdData <= DATA_W'(cfgQ);
          ADDR_COUNT: regRdData <= DATA_W'(countView);
          default:    regRdData <= '0;
        endcase
      end
    end
  end

  always_comb begin
    // Totalize path.
    actEdge = cfgQ.fallEdge ? (prevA & ~fA) : (~prevA & fA);
    gateOk  = (cfgQ.gateMode != GATE_ENABLE) | gateLvl;
    tUp     = 1'b0;
    tDown   = 1'b0;
    case (cfgQ.gateMode)
      GATE_ENABLE: tUp = actEdge & gateLvl;
      GATE_DOWN: begin
        tUp   = actEdge & ~gateLvl;
        tDown = actEdge & gateLvl;
      end
      default:     tUp = actEdge;
    endcase

    // Quadrature path: {prevA, prevB, A, B}.
    qTrans = {prevA, prevB, fA, fB};
    qFwd   = qTrans inside {4'b0010, 4'b1011, 4'b1101, 4'b0100};
    qRev   = qTrans inside {4'b1000, 4'b1110, 4'b0111, 4'b0001};
    qErr   = qTrans inside {4'b0011, 4'b1100, 4'b0110, 4'b1001};
    case (cfgQ.quadMult)
      MULT_X1: begin
        qUp   = (qTrans == 4'b0010);
        qDown = (qTrans == 4'b1000);
      end
      MULT_X2: begin
        qUp   = qFwd & (prevA != fA);
        qDown = qRev & (prevA != fA);
      end
      default: begin
        qUp   = qFwd;
        qDown = qRev;
      end
    endcase

    errNow            = cfgQ.encMode & qErr;
    strobes.up        = cfgQ.encMode ? (qUp & gateOk)   : tUp;
    strobes.down      = cfgQ.encMode ? (qDown & gateOk) : tDown;
    strobes.idxClear  = cfgQ.encMode & cfgQ.idxClrEn & ~prevZ & fZ;
    strobes.hostClear = regRdEn & (regAddr == ADDR_COUNT) & cfgQ.clrOnRead;
  end

  // R2: read data is presented on the following cycle.
  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

  // R12: an illegal transition never produces a count step.
  p_err_no_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    errNow |-> !(strobes.up || strobes.down));

  // R9: a low gate in enable mode blocks every step.
  p_gate_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.gateMode == GATE_ENABLE && !gateLvl) |-> !(strobes.up || strobes.down));

endmodule

// File: rtl/mmc_datapath.sv
module mmc_datapath
  import mmc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepStrobes_t     strobes,
  input  logic             width16,
  input  logic             holdMax,
  input  logic             encMode,
  output logic [CNT_W-1:0] countView
);

  localparam logic [CNT_W-1:0] NARROW_MAX = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CNT_W-1:0] WIDE_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] maxVal;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nextVal;
  logic             holdEn;

  assign maxVal    = width16 ? NARROW_MAX : WIDE_MAX;
  assign holdEn    = holdMax & ~encMode;
  assign countView = countQ & maxVal;

  always_comb begin
    base    = strobes.hostClear ? '0 : (countQ & maxVal);
    nextVal = base;
    if (strobes.idxClear) begin
      nextVal = '0;
    end else if (strobes.up && !strobes.down) begin
      if (base == maxVal) nextVal = holdEn ? base : '0;
      else                nextVal = base + 1'b1;
    end else if (strobes.down && !strobes.up) begin
      if (base == '0) nextVal = holdEn ? '0 : maxVal;
      else            nextVal = base - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else       countQ <= nextVal;
  end

  // R7: the register itself is narrowed while 16-bit width is selected.
  p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    width16 |=> (countQ[CNT_W-1:NARROW_W] == '0));

  // R6: saturation holds the maximum.
  p_hold_at_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdEn && strobes.up && !strobes.down && !strobes.idxClear &&
     !strobes.hostClear && countQ == maxVal) |=> (countQ == $past(countQ)));

  // R6: rollover policy wraps to zero.
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && strobes.up && !strobes.down && !strobes.idxClear &&
     !strobes.hostClear && countQ == maxVal) |=> (countQ == '0));

  // R11: an index event leaves the count at zero.
  p_index_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idxClear |=> (countQ == '0));

  // R8: a clearing read with no step leaves zero.
  p_cor_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hostClear && !strobes.up && !strobes.down) |=> (countQ == '0));

endmodule

// File: rtl/multiModeCounter.sv
module multiModeCounter
  import mmc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int DATA_W   = 32,
  parameter int CLK_MHZ  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseA,
  input  logic              phaseB,
  input  logic              indexZ,
  input  logic              gateIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic [CNT_W-1:0]  countOut,
  output logic              phaseErr
);

  localparam int NUM_FILT = 3;

  chanCfg_t              cfg;
  stepStrobes_t          strobes;
  logic [NUM_FILT-1:0]   rawVec;
  logic [NUM_FILT-1:0]   filtVec;

  assign rawVec = {indexZ, phaseB, pulseA};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FILT; gi++) begin : g_filt
      mmc_input_filter #(.CLK_MHZ(CLK_MHZ)) u_filt (
        .clk       (clk),
        .rstN      (rstN),
        .rawIn     (rawVec[gi]),
        .filtCode  (cfg.filtCode),
        .glitchMode(cfg.glitchMode),
        .filtOut   (filtVec[gi])
      );
    end
  endgenerate

  mmc_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fA        (filtVec[0]),
    .fB        (filtVec[1]),
    .fZ        (filtVec[2]),
    .gateRaw   (gateIn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .countView (countOut),
    .cfg       (cfg),
    .strobes   (strobes),
    .phaseErr  (phaseErr),
    .regRdData (regRdData),
    .regRdValid(regRdValid)
  );

  mmc_datapath #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .width16  (cfg.width16),
    .holdMax  (cfg.holdMax),
    .encMode  (cfg.encMode),
    .countView(countOut)
  );

endmodule

// File: tb/multiModeCounter_test.sv
module multiModeCounter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pulseA = 1'b0, phaseB = 1'b0, indexZ = 1'b0, gateIn = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic [31:0] countOut;
  logic        phaseErr;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  multiModeCounter uut (
    .clk(clk), .rstN(rstN), .pulseA(pulseA), .phaseB(phaseB), .indexZ(indexZ),
    .gateIn(gateIn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .regRdValid(regRdValid),
    .countOut(countOut), .phaseErr(phaseErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R2 actual=%0d expected=0 (reads never returned)", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: pops scoreboard entries as read data arrives.
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R2 actual=%h expected=none (unexpected read)", regRdData);
      end else begin
        check(tagQ.pop_front(), regRdData, expQ.pop_front());
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
    tick(1);
  endtask

  task automatic pulse(input int width, input int settle);
    pulseA = 1'b1; tick(width);
    pulseA = 1'b0; tick(settle);
  endtask

  task automatic setAB(input logic a, input logic b);
    pulseA = a; phaseB = b; tick(40);
  endtask

  task automatic fwdCycle();
    setAB(1, 0); setAB(1, 1); setAB(0, 1); setAB(0, 0);
  endtask

  task automatic revCycle();
    setAB(0, 1); setAB(1, 1); setAB(1, 0); setAB(0, 0);
  endtask

  task automatic countErr(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (phaseErr) n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int nErr;
    tick(4);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 count after reset", countOut, 32'h0);
    check("R1 phaseErr after reset", {31'b0, phaseErr}, 32'h0);
    expectRead(2'd0, 32'h0, "R1 config after reset");

    // R2 config readback, upper bits dropped
    wrCfg(32'hFFFF_FFFF);
    expectRead(2'd0, 32'h0000_7FFF, "R2 config readback");
    wrCfg(32'h0);
    expectRead(2'd0, 32'h0, "R2 config cleared");

    // R3 rising edges, R8 no clear without clear-on-read
    for (int i = 0; i < 5; i++) pulse(30, 40);
    check("R3 five rising edges", countOut, 32'd5);
    expectRead(2'd1, 32'd5, "R8 read without clear");
    expectRead(2'd1, 32'd5, "R8 count kept");
    // R3 falling edge selection
    wrCfg(32'h10);
    pulseA = 1'b1; tick(40);
    check("R3 rising ignored in falling mode", countOut, 32'd5);
    pulseA = 1'b0; tick(40);
    check("R3 falling edge counted", countOut, 32'd6);

    // R8 clear-on-read
    wrCfg(32'h18);
    expectRead(2'd1, 32'd6, "R8 clearing read value");
    expectRead(2'd1, 32'd0, "R8 zero after clearing read");

    // R4 debounce length
    wrCfg(32'h08);
    pulse(20, 40);
    check("R4 short pulse code0 rejected", countOut, 32'd0);
    pulse(30, 40);
    check("R4 long pulse code0 accepted", countOut, 32'd1);
    wrCfg(32'h08 | (32'd1 << 6));
    pulse(40, 70);
    check("R4 short pulse code1 rejected", countOut, 32'd1);
    pulse(60, 70);
    check("R4 long pulse code1 accepted", countOut, 32'd2);
    expectRead(2'd1, 32'd2, "R4 debounce total");

    // R5 glitch detect
    wrCfg(32'h28);
    pulse(3, 40);
    check("R5 narrow pulse passes", countOut, 32'd1);
    pulse(3, 3); pulse(3, 40);
    check("R5 second pulse inside lockout ignored", countOut, 32'd2);
    expectRead(2'd1, 32'd2, "R5 glitch total");

    // R7 / R6 overflow policy via gate-decrement
    wrCfg(32'h4008);
    gateIn = 1'b1; tick(5);
    pulse(30, 40);
    check("R7 32-bit decrement from zero", countOut, 32'hFFFF_FFFF);
    gateIn = 1'b0; tick(5);
    pulse(30, 40);
    check("R6 32-bit rollover to zero", countOut, 32'h0);
    wrCfg(32'h400A);
    gateIn = 1'b1; tick(5);
    pulse(30, 40);
    check("R7 16-bit decrement from zero", countOut, 32'h0000_FFFF);
    wrCfg(32'h400E);
    gateIn = 1'b0; tick(5);
    pulse(30, 40);
    check("R6 hold at 16-bit max", countOut, 32'h0000_FFFF);
    wrCfg(32'h400A);
    pulse(30, 40);
    check("R6 16-bit rollover", countOut, 32'h0);
    wrCfg(32'h400E);
    gateIn = 1'b1; tick(5);
    pulse(30, 40);
    check("R6 hold at zero on decrement", countOut, 32'h0);

    // R9 gate enable
    wrCfg(32'h2008);
    gateIn = 1'b0; tick(5);
    pulse(30, 40);
    check("R9 gate low blocks", countOut, 32'd0);
    gateIn = 1'b1; tick(5);
    pulse(30, 40);
    check("R9 gate high counts", countOut, 32'd1);
    expectRead(2'd1, 32'd1, "R9 gated total");
    gateIn = 1'b0;

    // R10 quadrature multipliers
    wrCfg(32'h809);
    fwdCycle();
    check("R10 x4 forward", countOut, 32'd4);
    revCycle();
    check("R10 x4 reverse", countOut, 32'd0);
    wrCfg(32'h409);
    fwdCycle();
    check("R10 x2 forward", countOut, 32'd2);
    wrCfg(32'h009);
    fwdCycle();
    check("R10 x1 forward", countOut, 32'd3);
    revCycle(); revCycle();
    check("R10 x1 reverse twice", countOut, 32'd1);
    expectRead(2'd1, 32'd1, "R10 encoder total");

    // R11 index clear
    wrCfg(32'h1809);
    fwdCycle();
    indexZ = 1'b1; tick(30); indexZ = 1'b0; tick(40);
    check("R11 index clears", countOut, 32'd0);
    wrCfg(32'h809);
    fwdCycle();
    indexZ = 1'b1; tick(30); indexZ = 1'b0; tick(40);
    check("R11 index ignored when disabled", countOut, 32'd4);
    expectRead(2'd1, 32'd4, "R11 total");

    // R12 illegal transitions
    wrCfg(32'h809);
    pulseA = 1'b1; phaseB = 1'b1;
    countErr(50, nErr);
    check("R12 error pulse width 00->11", nErr, 32'd1);
    check("R12 count unchanged 00->11", countOut, 32'd0);
    pulseA = 1'b0; phaseB = 1'b0;
    countErr(50, nErr);
    check("R12 error pulse width 11->00", nErr, 32'd1);
    check("R12 count unchanged 11->00", countOut, 32'd0);

    tick(5);
    finishRun();
  end

endmodule